// File: doc/BRIEF.md
# Wired-AND Scan Address Interrogation Arbiter

This block is the address-discovery engine of a scan-bridge device that shares a multidrop backplane test bus with others of its kind. All devices see the same instruction scans. When the interrogation opcode is loaded, each device serially offers the ones-complement of its slot address on the shared test-data-out line, LSB first. A zero pulls the line low hard. A one is only a weak high. Every device watches the line while it drives, and a device that sees a low where it offered a high drops out of the current round.

Each instruction scan therefore yields exactly one winning address. The winner then parks in a wait-for-reset state. The losers re-arm for the next scan, so repeated scans read every address out once. Once all devices have reported, the line floats high for the whole scan, and the tester reads all ones. For this reason the slot address zero is not allowed.

The block takes the TAP phase strobes (capture, shift, update of the instruction path), the instruction value present at update, the slot address pins and the sensed bus level. It returns a pull-low request, an output enable and its arbitration state. A go-to-wait strobe, or reset, returns it to the idle state.

Top module: `scan_addr_arbiter`

## Requirements
- R1: After reset, and in the cycle after `go_wait` is high, `state_o` is 0 (idle) and `drive_en` and `drive_low` are 0.
- R2: An `update_ir` strobe with `ir_value` equal to 8'h3A moves the idle state to 1 (armed). Any other value leaves the idle state unchanged.
- R3: A `capture_ir` strobe in the armed state loads the ones-complement of `slot_addr` and moves to state 2 (presenting). In each of the next AW `shift_ir` cycles, `drive_en` is 1 and `drive_low` is 1 exactly when the offered complement bit is 0. Bits are offered LSB first, so on the first shift cycle `drive_low` equals `slot_addr[0]`.
- R4: If a presenting device offers a weak 1 (`drive_en`=1, `drive_low`=0) and senses `bus_sense`=0, it moves to state 3 (lost). It keeps `drive_en` at 0 for the rest of that scan.
- R5: From the lost state, an `update_ir` with 8'h3A returns the device to the armed state, so it retries on the next scan.
- R6: Once all AW bits have been offered without a mismatch, `drive_en` stays 0 for any further shift cycles of that scan. The next `update_ir` moves the device to state 4 (done), whatever the opcode.
- R7: In the done state, `capture_ir`, `shift_ir` and `update_ir` have no effect. `drive_en` stays 0 until reset or `go_wait`.
- R8: An `update_ir` with a value other than 8'h3A in the armed, presenting (not yet complete) or lost state returns the device to idle.
- R9: When several devices share the bus (modelled as a wired-AND), each scan reads back the ones-complement of exactly one address. Addresses come out in descending order of their bit-reversed value, so 000001, 010100, 100000 are read in that order.
- R10: Once every device is in the done state, an interrogation scan reads all ones on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go_wait | input | 1 | Go-to-wait command strobe, returns to idle |
| capture_ir | input | 1 | Capture phase strobe of the instruction path |
| shift_ir | input | 1 | Shift phase enable of the instruction path, one bit per cycle |
| update_ir | input | 1 | Update phase strobe of the instruction path |
| ir_value | input | IRW | Instruction value present at the update strobe |
| slot_addr | input | AW | Slot address pins of this device |
| bus_sense | input | 1 | Sensed level of the shared test-data-out line |
| drive_low | output | 1 | Request to pull the shared line low |
| drive_en | output | 1 | Output enable: the device is presenting a bit (weak high unless drive_low) |
| state_o | output | 3 | Arbitration state: 0 idle, 1 armed, 2 presenting, 3 lost, 4 done |

## Verification
The in-module assertions check, on every cycle, the local rules of the state machine. A pull-low request never appears without the output enable. A sensed mismatch on an offered high always leads to the lost state. A non-interrogation opcode at update exits arbitration. The done state is left only through go-to-wait and never drives. The go-to-wait command always lands in idle. Only the bench's multi-device scenarios can show the global outcome: that wired-AND arbitration across several devices picks exactly one winner per scan in the bit-reversed order, that losers re-arm and win later, and that the final scan reads all ones.

// File: rtl/scan_addr_arbiter.sv
module scan_addr_arbiter #(
  parameter int AW = 6,
  parameter int IRW = 8,
  parameter int unsigned INTERROG_OP = 'h3A
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go_wait,
  input  logic           capture_ir,
  input  logic           shift_ir,
  input  logic           update_ir,
  input  logic [IRW-1:0] ir_value,
  input  logic [AW-1:0]  slot_addr,
  input  logic           bus_sense,
  output logic           drive_low,
  output logic           drive_en,
  output logic [2:0]     state_o
);
  localparam int CW = $clog2(AW + 1);

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ARMED = 3'd1,
    S_SHIFT = 3'd2,
    S_LOST  = 3'd3,
    S_DONE  = 3'd4
  } st_t;

  st_t           st;
  logic [AW-1:0] sr;
  logic [CW-1:0] cnt;

  wire is_op = (ir_value == IRW'(INTERROG_OP));
  wire sent  = (cnt == CW'(AW));
  wire lose  = drive_en && (bus_sense != sr[0]);

  assign drive_en  = shift_ir && (st == S_SHIFT) && !sent;
  assign drive_low = drive_en && !sr[0];
  assign state_o   = st;

  always_ff @(posedge clk) begin
    if (!rst_n || go_wait) begin
      st  <= S_IDLE;
      sr  <= '0;
      cnt <= '0;
    end else if (update_ir) begin
      case (st)
        S_IDLE:          if (is_op) st <= S_ARMED;
        S_ARMED, S_LOST: st <= is_op ? S_ARMED : S_IDLE;
        S_SHIFT:         st <= sent ? S_DONE : (is_op ? S_ARMED : S_IDLE);
        default:         st <= st;
      endcase
    end else if (capture_ir) begin
      if (st == S_ARMED) begin
        sr  <= ~slot_addr;
        cnt <= '0;
        st  <= S_SHIFT;
      end
    end else if (drive_en) begin
      if (lose) begin
        st <= S_LOST;
      end else begin
        sr  <= sr >> 1;
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R1
  idle_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_wait |=> (state_o == 3'd0 && !drive_en));

  // R3
  low_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_low |-> drive_en);

  // R4
  backoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && !drive_low && !bus_sense && !go_wait) |=> (state_o == 3'd3));

  // R6
  win_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SHIFT && sent && update_ir && !go_wait) |=> (state_o == 3'd4));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd4 && !go_wait) |=> (state_o == 3'd4));

  // R7
  done_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd4) |-> !drive_en);

  // R8
  exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (update_ir && !is_op && !go_wait && (st == S_ARMED || st == S_LOST))
      |=> (state_o == 3'd0));
endmodule

// File: tb/scan_addr_arbiter_tb.sv
`timescale 1ns/1ps
module scan_addr_arbiter_tb_top;
  localparam int AW = 6;
  localparam int N  = 3;
  localparam logic [7:0] OP = 8'h3A;

  logic clk = 0, rst_n = 0, go_wait = 0, cap = 0, shf = 0, upd = 0;
  logic [7:0] ir = '0;
  logic [AW-1:0] addr [N];
  logic [N-1:0] de, dl;
  logic [2:0] st [N];
  wire bus = ~(|dl);

  always #10 clk = ~clk;

  for (genvar i = 0; i < N; i++) begin : g_dev
    scan_addr_arbiter #(.AW(AW), .IRW(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .go_wait(go_wait), .capture_ir(cap),
      .shift_ir(shf), .update_ir(upd), .ir_value(ir), .slot_addr(addr[i]),
      .bus_sense(bus), .drive_low(dl[i]), .drive_en(de[i]), .state_o(st[i]));
  end

  int checks = 0, errs = 0;
  bit active [N];
  logic [N-1:0] fd_en, fd_low;
  logic [15:0] bits;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int rev(input logic [AW-1:0] a);
    int r = 0;
    for (int b = 0; b < AW; b++) r = (r << 1) | int'(a[b]);
    return r;
  endfunction

  function automatic int pick();
    int w = -1;
    for (int i = 0; i < N; i++)
      if (active[i] && (w < 0 || rev(addr[i]) > rev(addr[w]))) w = i;
    return w;
  endfunction

  task automatic pulse_update(input logic [7:0] op);
    @(negedge clk); ir = op; upd = 1;
    @(negedge clk); upd = 0;
  endtask

  task automatic pulse_capture();
    @(negedge clk); cap = 1;
    @(negedge clk); cap = 0;
  endtask

  task automatic pulse_wait();
    @(negedge clk); go_wait = 1;
    @(negedge clk); go_wait = 0;
  endtask

  task automatic shift_n(input int n);
    bits = '1;
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      shf = 1;
      #1;
      bits[k] = bus;
      if (k == 0) begin fd_en = de; fd_low = dl; end
      @(negedge clk);
    end
    shf = 0;
  endtask

  task automatic round(input bit first);
    int w;
    logic [AW-1:0] got;
    w = pick();
    if (first) pulse_update(OP);
    pulse_capture();
    shift_n(AW + 2);
    got = ~bits[AW-1:0];
    if (w < 0) begin
      chk(bits[AW+1:0] == '1, "R10 all-ones readout", int'(bits[AW+1:0]), (1 << (AW + 2)) - 1);
    end else begin
      chk(got == addr[w], "R9 readout address", int'(got), int'(addr[w]));
      chk(bits[AW+1:AW] == 2'b11, "R6 released after last bit", int'(bits[AW+1:AW]), 3);
      for (int i = 0; i < N; i++) if (active[i]) begin
        chk(fd_en[i] == 1'b1, "R3 enable on first bit", int'(fd_en[i]), 1);
        chk(fd_low[i] == addr[i][0], "R3 LSB first drive", int'(fd_low[i]), int'(addr[i][0]));
        if (i != w) chk(st[i] == 3'd3, "R4 loser backs off", int'(st[i]), 3);
      end
    end
    pulse_update(OP);
    for (int i = 0; i < N; i++) begin
      if (i == w) begin
        chk(st[i] == 3'd4, "R6 winner done", int'(st[i]), 4);
        active[i] = 0;
      end else if (active[i]) chk(st[i] == 3'd1, "R5 loser re-armed", int'(st[i]), 1);
      else chk(st[i] == 3'd4, "R7 done holds", int'(st[i]), 4);
    end
  endtask

  task automatic enumerate();
    for (int i = 0; i < N; i++) active[i] = 1;
    for (int r = 0; r <= N; r++) round(r == 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    addr[0] = 6'b010100; addr[1] = 6'b100000; addr[2] = 6'b000001;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      chk(st[i] == 3'd0, "R1 reset state", int'(st[i]), 0);
      chk(de[i] == 1'b0, "R1 reset no drive", int'(de[i]), 0);
    end
    // R2: wrong opcode keeps idle
    pulse_update(8'h3B);
    chk(st[0] == 3'd0, "R2 other opcode idle", int'(st[0]), 0);
    pulse_update(OP);
    chk(st[0] == 3'd1, "R2 armed", int'(st[0]), 1);
    pulse_wait();
    chk(st[0] == 3'd0, "R1 go_wait idle", int'(st[0]), 0);
    // directed enumeration
    enumerate();
    // R7: done ignores everything
    pulse_update(8'h00);
    pulse_capture();
    shift_n(3);
    chk(bits[2:0] == 3'b111 && de == '0, "R7 done silent", int'(bits[2:0]), 7);
    chk(st[1] == 3'd4, "R7 done ignores update", int'(st[1]), 4);
    pulse_wait();
    chk(st[1] == 3'd0, "R1 go_wait from done", int'(st[1]), 0);
    // R8: exit from presenting and armed
    pulse_update(OP);
    pulse_capture();
    chk(st[2] == 3'd2, "R3 presenting", int'(st[2]), 2);
    shift_n(2);
    pulse_update(8'h15);
    for (int i = 0; i < N; i++) chk(st[i] == 3'd0, "R8 exit to idle", int'(st[i]), 0);
    // random trials
    for (int t = 0; t < 25; t++) begin
      for (int i = 0; i < N; i++) begin
        bit dup;
        do begin
          addr[i] = AW'($urandom_range(1, (1 << AW) - 1));
          dup = 0;
          for (int j = 0; j < i; j++) if (addr[j] == addr[i]) dup = 1;
        end while (dup);
      end
      pulse_wait();
      enumerate();
    end
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule